// File: doc/BRIEF.md
# ECC Read Error Status Tracker

This block collects the outcome of every flash read that passes through an ECC decoder, on two independent read paths: instruction fetches and data loads. Each read report says whether the decoder corrected a single-bit error, detected an uncorrectable double-bit error, or both. The tracker keeps a sticky two-bit code per path and a small saturating count of corrected errors, and presents them in one 32-bit status word.

Software reads the status word by pulsing `rd_stb`. The word on `rd_data` is valid in that cycle, and the tracked state is cleared at the following clock edge. A report that arrives in the same cycle as the read is not lost. It is kept as the only content of the freshly cleared state. While `ecc_en` is low, all reports are ignored.

Top module: `ecc_err_status_top`

## Requirements
- R1: After reset, `rd_data` is 0x00000000.
- R2: Bits [28:27] hold the instruction-path code and bits [26:25] hold the data-path code. A double-bit report sets the code's bit 0 (01). A single-bit corrected report sets its bit 1 (10). Both kinds of report give 11.
- R3: Codes accumulate by OR. A single-bit report followed by a double-bit report in the same window gives 11, and no later report lowers a code until a read.
- R4: A cycle with `rd_stb` high shows the current state on `rd_data`. When that cycle has no new reports, both codes read 00 from the next cycle on.
- R5: Bits [24:22] count single-bit corrected reports. Each path that reports one in a cycle adds one, so both paths together add two. The count saturates at 7.
- R6: A double-bit report leaves the counter unchanged.
- R7: A read clears the counter.
- R8: A report that arrives in the same cycle as `rd_stb` is held after the clear. The counter then equals the number of single-bit reports in that cycle.
- R9: While `ecc_en` is low, reports change neither the codes nor the counter.
- R10: Bits [31:29], [21:20] and every bit below 20 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ecc_en | input | 1 | ECC status reporting enable |
| ib_vld | input | 1 | Instruction-path read report valid |
| ib_sbe | input | 1 | Instruction-path single-bit error corrected |
| ib_dbe | input | 1 | Instruction-path double-bit error detected |
| db_vld | input | 1 | Data-path read report valid |
| db_sbe | input | 1 | Data-path single-bit error corrected |
| db_dbe | input | 1 | Data-path double-bit error detected |
| rd_stb | input | 1 | Status word read; clears state at the next edge |
| rd_data | output | 32 | Status word |

## Verification
On every cycle, the assertions check four things. Codes never lose a bit outside a read. A read with no new reports empties the codes and the counter. The counter holds still without single-bit reports and never wraps from 7. Nothing moves while reporting is disabled. The bench scenarios show the behaviour that depends on history: the exact encodings, the 10-then-01 merge into 11, the counter reaching and holding at 7, and the collision of a read with a new report. A reference model then follows long random streams with occasional reads.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;

   localparam int unsigned CODE_W      = 2;
   localparam int unsigned CODE_SBE    = 1;  // bit set for a corrected single-bit error
   localparam int unsigned CODE_DBE    = 0;  // bit set for a detected double-bit error
   localparam int unsigned DEF_STAT_W  = 32;
   localparam int unsigned DEF_IB_LSB  = 27;
   localparam int unsigned DEF_DB_LSB  = 25;
   localparam int unsigned DEF_CNT_LSB = 22;
   localparam int unsigned DEF_CNT_W   = 3;
   localparam int unsigned NUM_PATH    = 2;

   typedef logic [CODE_W-1:0] ecc_code_t;

   typedef struct packed {
      logic vld;
      logic sbe;
      logic dbe;
   } ecc_rpt_t;

endpackage

// File: rtl/ecc_evt_qual.sv
module ecc_evt_qual
   import ecc_stat_pkg::*;
(
   input  logic      en,
   input  ecc_rpt_t  rpt,
   output ecc_code_t set_bits,
   output logic      sbe_hit
);

   logic live;

   always_comb begin
      live               = en & rpt.vld;
      set_bits           = '0;
      set_bits[CODE_SBE] = live & rpt.sbe;
      set_bits[CODE_DBE] = live & rpt.dbe;
      sbe_hit            = live & rpt.sbe;
   end

endmodule

// File: rtl/ecc_code_reg.sv
module ecc_code_reg
   import ecc_stat_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  ecc_code_t set_bits,
   output ecc_code_t code
);

   ecc_code_t base;
   ecc_code_t code_nxt;

   always_comb begin
      base     = clr ? '0 : code;
      code_nxt = base | set_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code <= '0;
      else        code <= code_nxt;
   end

endmodule

// File: rtl/ecc_sbe_counter.sv
module ecc_sbe_counter #(
   parameter int unsigned CNT_W    = 3,
   parameter int unsigned INC_W    = 2,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] cnt
);

   localparam int unsigned SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
   localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

   logic [SUM_W-1:0] base;
   logic [SUM_W-1:0] sum;
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      base = clr ? '0 : SUM_W'(cnt);
      sum  = base + SUM_W'(inc);
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb cnt_nxt = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
      end else begin : g_wrap
         always_comb cnt_nxt = sum[CNT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end

endmodule

// File: rtl/ecc_stat_pack.sv
module ecc_stat_pack
   import ecc_stat_pkg::*;
#(
   parameter int unsigned STAT_W  = 32,
   parameter int unsigned IB_LSB  = 27,
   parameter int unsigned DB_LSB  = 25,
   parameter int unsigned CNT_LSB = 22,
   parameter int unsigned CNT_W   = 3
) (
   input  ecc_code_t        ib_code,
   input  ecc_code_t        db_code,
   input  logic [CNT_W-1:0] cnt,
   output logic [STAT_W-1:0] word
);

   always_comb begin
      word                        = '0;
      word[IB_LSB  +: CODE_W]     = ib_code;
      word[DB_LSB  +: CODE_W]     = db_code;
      word[CNT_LSB +: CNT_W]      = cnt;
   end

endmodule

// File: rtl/ecc_err_status_top.sv
module ecc_err_status_top
   import ecc_stat_pkg::*;
#(
   parameter int unsigned STAT_W   = DEF_STAT_W,
   parameter int unsigned IB_LSB   = DEF_IB_LSB,
   parameter int unsigned DB_LSB   = DEF_DB_LSB,
   parameter int unsigned CNT_LSB  = DEF_CNT_LSB,
   parameter int unsigned CNT_W    = DEF_CNT_W,
   parameter bit          SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ecc_en,
   input  logic              ib_vld,
   input  logic              ib_sbe,
   input  logic              ib_dbe,
   input  logic              db_vld,
   input  logic              db_sbe,
   input  logic              db_dbe,
   input  logic              rd_stb,
   output logic [STAT_W-1:0] rd_data
);

   localparam int unsigned INC_W = $clog2(NUM_PATH + 1);

   // elaboration-time checks of the field layout
   generate
      if (IB_LSB + CODE_W > STAT_W || DB_LSB + CODE_W > STAT_W || CNT_LSB + CNT_W > STAT_W) begin : g_bad_fit
         $error("ecc_err_status_top: a field lies outside the status word");
      end
      if ((IB_LSB < DB_LSB + CODE_W) && (DB_LSB < IB_LSB + CODE_W)) begin : g_bad_ib_db
         $error("ecc_err_status_top: path code fields overlap");
      end
      if ((IB_LSB < CNT_LSB + CNT_W) && (CNT_LSB < IB_LSB + CODE_W)) begin : g_bad_ib_cnt
         $error("ecc_err_status_top: instruction code overlaps counter");
      end
      if ((DB_LSB < CNT_LSB + CNT_W) && (CNT_LSB < DB_LSB + CODE_W)) begin : g_bad_db_cnt
         $error("ecc_err_status_top: data code overlaps counter");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("ecc_err_status_top: counter width must be positive");
      end
   endgenerate

   ecc_rpt_t              rpt      [NUM_PATH];
   ecc_code_t             set_bits [NUM_PATH];
   ecc_code_t             code     [NUM_PATH];
   logic [NUM_PATH-1:0]   sbe_hit;
   logic [INC_W-1:0]      inc;

   always_comb begin
      rpt[0] = '{vld: ib_vld, sbe: ib_sbe, dbe: ib_dbe};
      rpt[1] = '{vld: db_vld, sbe: db_sbe, dbe: db_dbe};
   end

   generate
      for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
         ecc_evt_qual u_qual (
            .en       (ecc_en),
            .rpt      (rpt[p]),
            .set_bits (set_bits[p]),
            .sbe_hit  (sbe_hit[p])
         );
         ecc_code_reg u_code (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (rd_stb),
            .set_bits (set_bits[p]),
            .code     (code[p])
         );
      end
   endgenerate

   always_comb begin
      inc = '0;
      for (int p = 0; p < NUM_PATH; p++) inc = inc + INC_W'(sbe_hit[p]);
   end

   logic [CNT_W-1:0] cnt;

   ecc_sbe_counter #(
      .CNT_W    (CNT_W),
      .INC_W    (INC_W),
      .SATURATE (SATURATE)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rd_stb),
      .inc   (inc),
      .cnt   (cnt)
   );

   ecc_stat_pack #(
      .STAT_W  (STAT_W),
      .IB_LSB  (IB_LSB),
      .DB_LSB  (DB_LSB),
      .CNT_LSB (CNT_LSB),
      .CNT_W   (CNT_W)
   ) u_pack (
      .ib_code (code[0]),
      .db_code (code[1]),
      .cnt     (cnt),
      .word    (rd_data)
   );

endmodule

// File: rtl/ecc_stat_chk.sv
module ecc_stat_chk
   import ecc_stat_pkg::*;
#(
   parameter int unsigned STAT_W  = 32,
   parameter int unsigned IB_LSB  = 27,
   parameter int unsigned DB_LSB  = 25,
   parameter int unsigned CNT_LSB = 22,
   parameter int unsigned CNT_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ecc_en,
   input logic              ib_vld,
   input logic              ib_sbe,
   input logic              ib_dbe,
   input logic              db_vld,
   input logic              db_sbe,
   input logic              db_dbe,
   input logic              rd_stb,
   input logic [STAT_W-1:0] rd_data
);

   localparam logic [CNT_W-1:0] CMAX = '1;

   logic              any_rpt;
   logic              any_sbe;
   logic [CODE_W-1:0] ib_c;
   logic [CODE_W-1:0] db_c;
   logic [CNT_W-1:0]  c_now;

   always_comb begin
      any_rpt = ecc_en & ((ib_vld & (ib_sbe | ib_dbe)) | (db_vld & (db_sbe | db_dbe)));
      any_sbe = ecc_en & ((ib_vld & ib_sbe) | (db_vld & db_sbe));
      ib_c    = rd_data[IB_LSB +: CODE_W];
      db_c    = rd_data[DB_LSB +: CODE_W];
      c_now   = rd_data[CNT_LSB +: CNT_W];
   end

   AST_CODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> (((ib_c & $past(ib_c)) == $past(ib_c)) && ((db_c & $past(db_c)) == $past(db_c)))); // R3

   AST_READ_CLEARS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !any_rpt) |=> (ib_c == '0 && db_c == '0)); // R4

   AST_READ_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !any_sbe) |=> (c_now == '0)); // R7

   AST_COUNT_ONLY_SBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb && !any_sbe) |=> $stable(c_now)); // R6

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb && c_now == CMAX) |=> (c_now == CMAX)); // R5

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ecc_en && !rd_stb) |=> $stable(rd_data)); // R9

endmodule

bind ecc_err_status_top ecc_stat_chk #(
   .STAT_W  (STAT_W),
   .IB_LSB  (IB_LSB),
   .DB_LSB  (DB_LSB),
   .CNT_LSB (CNT_LSB),
   .CNT_W   (CNT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ecc_en  (ecc_en),
   .ib_vld  (ib_vld),
   .ib_sbe  (ib_sbe),
   .ib_dbe  (ib_dbe),
   .db_vld  (db_vld),
   .db_sbe  (db_sbe),
   .db_dbe  (db_dbe),
   .rd_stb  (rd_stb),
   .rd_data (rd_data)
);

// File: tb/sim_ecc_err_status_top.sv
module sim_ecc_err_status_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ecc_en = 1'b0;
   logic        ib_vld = 1'b0, ib_sbe = 1'b0, ib_dbe = 1'b0;
   logic        db_vld = 1'b0, db_sbe = 1'b0, db_dbe = 1'b0;
   logic        rd_stb = 1'b0;
   logic [31:0] rd_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [1:0] m_ib = '0;
   logic [1:0] m_db = '0;
   int         m_cnt = 0;

   always #5 clk = ~clk;

   ecc_err_status_top u0 (
      .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en),
      .ib_vld(ib_vld), .ib_sbe(ib_sbe), .ib_dbe(ib_dbe),
      .db_vld(db_vld), .db_sbe(db_sbe), .db_dbe(db_dbe),
      .rd_stb(rd_stb), .rd_data(rd_data)
   );

   function automatic logic [31:0] exp_word(logic [1:0] ic, logic [1:0] dc, int c);
      logic [31:0] w;
      w        = '0;
      w[28:27] = ic;
      w[26:25] = dc;
      w[24:22] = c[2:0];
      return w;
   endfunction

   task automatic check_now(string tag);
      logic [31:0] e;
      e = exp_word(m_ib, m_db, m_cnt);
      n_chk++;
      if (rd_data !== e) begin
         n_fail++;
         $display("FAIL %s: rd_data=%h expected %h", tag, rd_data, e);
      end
      n_chk++;
      if ((rd_data & 32'hE03F_FFFF) !== 32'h0) begin
         n_fail++;
         $display("FAIL R10: reserved bits=%h expected 00000000", rd_data & 32'hE03F_FFFF);
      end
   endtask

   // drive one cycle's inputs, check the current word, advance the model
   task automatic step(bit en, bit iv, bit is, bit id, bit dv, bit ds, bit dd, bit rd, string tag);
      int inc;
      ecc_en = en; ib_vld = iv; ib_sbe = is; ib_dbe = id;
      db_vld = dv; db_sbe = ds; db_dbe = dd; rd_stb = rd;
      #1;
      check_now(tag);
      if (rd) begin m_ib = '0; m_db = '0; m_cnt = 0; end
      if (en && iv) m_ib = m_ib | {is, id};
      if (en && dv) m_db = m_db | {ds, dd};
      inc   = int'(en && iv && is) + int'(en && dv && ds);
      m_cnt = (m_cnt + inc > 7) ? 7 : m_cnt + inc;
      @(negedge clk);
   endtask

   initial begin
      #(150_000 * 10);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4821));
      repeat (3) @(negedge clk);
      check_now("R1");
      rst_n = 1'b1;
      @(negedge clk);

      step(1, 1,1,0, 0,0,0, 0, "R1");   // ib single-bit
      step(1, 1,0,1, 0,0,0, 0, "R2");   // sees 10; then ib double-bit
      step(1, 0,0,0, 0,0,0, 1, "R3");   // sees 11 count 1, read clears
      step(1, 0,0,0, 1,0,1, 0, "R4");   // sees cleared word; db double-bit
      step(1, 0,0,0, 0,0,0, 0, "R6");   // sees db 01, count 0
      for (int i = 0; i < 5; i++) step(1, 1,1,0, 1,1,0, 0, "R5");
      step(1, 1,1,0, 0,0,0, 1, "R5");   // sees saturated 7; collision read
      step(1, 0,0,0, 0,0,0, 0, "R8");   // sees only the colliding report
      step(1, 0,0,0, 0,0,0, 1, "R8");
      step(1, 0,0,0, 0,0,0, 0, "R7");   // counter cleared
      step(0, 1,1,1, 1,1,1, 0, "R7");   // disabled reports
      step(0, 1,1,1, 1,1,1, 0, "R9");
      step(1, 0,0,0, 0,0,0, 0, "R9");

      for (int k = 0; k < 3000; k++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[0] | r[1] | r[2], r[3], r[4], r[5] & r[6], r[7], r[8], r[9] & r[10],
              (r[15:11] == 5'd0), "R3");
      end
      step(1, 0,0,0, 0,0,0, 0, "R3");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule